// File: doc/BRIEF.md
# Link Transmit Framer with Loopback Drain Sequencer

This block produces one 9-bit link character on every rising edge of the transmit clock. Each character is a control flag plus an 8-bit value. An upstream byte source offers items through a valid/ready handshake. Each item is either a frame byte or a request to close the frame. Accepted bytes go out as data characters, and a close request goes out as the end-of-frame control character. When nothing is offered, the block emits idle control characters. A byte-sync strobe goes out alongside the character stream. It marks the first character of each frame and the character that follows a loopback switch.

A one-cycle pulse on the loopback request input toggles the loopback control output, but only after a fixed drain sequence. The block first stops accepting items and sends end-of-frame. It then sends a first run of idles, flips the loopback output, and sends a second run of idles of the same length. Normal framing then resumes, and the byte-sync strobe marks the resumption. A request that arrives while a sequence is running is remembered and starts a new sequence as soon as the current one ends.

Top module: `lnk_tx_framer`

## Requirements
- R1: While reset is held, the character outputs show an idle character (control flag 1, value EEh), byte-sync is 0, loopback is 0 and src_ready is 1.
- R2: In a cycle with no accepted item and no sequence activity, the next character is idle: control flag 1, value EEh.
- R3: A byte accepted with src_eof low appears on the next edge as a data character: control flag 0 and the same 8-bit value, including FFh and 00h.
- R4: An item accepted with src_eof high produces an end-of-frame character on the next edge (control flag 1, value D0h) and closes the frame.
- R5: Byte-sync is 1 on the first data character after reset, after an end-of-frame, or after a drain sequence. It is 0 on later data characters and on idles inside an open frame.
- R6: One cycle after a loopback request pulse is registered, src_ready is 0 and an end-of-frame character is sent. The next 16 characters are idles with the loopback output unchanged.
- R7: The loopback output flips on the edge that emits the first idle of the second run. It keeps the new state through that run of 16 idles.
- R8: The character after the second idle run carries byte-sync = 1. If no further request is pending, src_ready is 1 again in that cycle.
- R9: src_ready stays 0 from the end-of-frame of a sequence through its last idle. Items offered in that time are not consumed, and the first byte offered at resumption is the one sent.
- R10: A loopback request that arrives during a sequence is held. A new sequence starts at the resumption cycle: its end-of-frame carries byte-sync = 1 and src_ready stays 0.
- R11: Whenever the control flag is 1, the value is one of D0h, EEh or FFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | Upstream offers an item |
| src_data | input | 8 | Frame byte offered |
| src_eof | input | 1 | Item is a frame-close request, not a byte |
| src_ready | output | 1 | Block accepts the offered item this cycle |
| lb_req | input | 1 | One-cycle pulse asking to toggle loopback |
| tx_ctl | output | 1 | Control flag of the outgoing character |
| tx_val | output | 8 | Value of the outgoing character |
| tx_sync | output | 1 | Byte-sync strobe marking frame starts |
| lpbk_out | output | 1 | Loopback control output |

## Verification
Two functions can meet in one cycle: a loopback request can arrive while an item is being accepted, and a held request can fall due in the same cycle as the resumption strobe. The first case is provoked by pulsing the request together with a valid byte. That byte must still go out with frame-start sync, and the next offered byte must be refused while end-of-frame goes out. The second case is provoked by a request in the middle of the first idle run. The resumption character must then be an end-of-frame that carries sync, followed by a complete second sequence that restores the loopback state.

// File: rtl/lnk_tx_pkg.sv
package lnk_tx_pkg;

  localparam logic [7:0] CODE_EOF = 8'hD0;
  localparam logic [7:0] CODE_IDL = 8'hEE;
  localparam logic [7:0] CODE_VLF = 8'hFF;

  typedef struct packed {
    logic       ctl;
    logic [7:0] val;
  } lnk_char_t;

  typedef enum logic [1:0] {
    PH_RUN     = 2'd0,
    PH_DRAIN_A = 2'd1,
    PH_DRAIN_B = 2'd2
  } phase_e;

  function automatic lnk_char_t mk_ctl(input logic [7:0] code);
    lnk_char_t c;
    c.ctl = 1'b1;
    c.val = code;
    return c;
  endfunction

  function automatic lnk_char_t mk_data(input logic [7:0] b);
    lnk_char_t c;
    c.ctl = 1'b0;
    c.val = b;
    return c;
  endfunction

  function automatic logic is_ctl_code(input logic [7:0] v);
    return (v == CODE_EOF) || (v == CODE_IDL) || (v == CODE_VLF);
  endfunction

endpackage

// File: rtl/lnk_tx_seq.sv
module lnk_tx_seq
  import lnk_tx_pkg::*;
#(
  parameter int DRAIN_LEN = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   lb_req,
  output phase_e phase,
  output logic   pend,
  output logic   seq_start,
  output logic   lb_flip,
  output logic   seq_done,
  output logic   lb_state
);

  localparam int CW = (DRAIN_LEN > 1) ? $clog2(DRAIN_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(DRAIN_LEN - 1);

  logic [CW-1:0] cnt;
  logic          run_last;

  assign run_last  = (cnt == LAST);
  assign seq_start = (phase == PH_RUN) && pend;
  assign lb_flip   = (phase == PH_DRAIN_B) && (cnt == '0);
  assign seq_done  = (phase == PH_DRAIN_B) && run_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_RUN;
      cnt      <= '0;
      pend     <= 1'b0;
      lb_state <= 1'b0;
    end else begin
      pend     <= lb_req | (pend & ~seq_start);
      lb_state <= lb_state ^ lb_flip;
      case (phase)
        PH_RUN: begin
          if (seq_start) begin
            phase <= PH_DRAIN_A;
            cnt   <= '0;
          end
        end
        PH_DRAIN_A: begin
          if (run_last) begin
            phase <= PH_DRAIN_B;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DRAIN_B: begin
          if (run_last) begin
            phase <= PH_RUN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          phase <= PH_RUN;
          cnt   <= '0;
        end
      endcase
    end
  end

  // R10
  pend_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_RUN && pend) |=> pend);

endmodule

// File: rtl/lnk_tx_charsel.sv
module lnk_tx_charsel
  import lnk_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic [7:0] src_data,
  input  logic       src_eof,
  input  logic       seq_start,
  input  logic       seq_done,
  output lnk_char_t  tx_char,
  output logic       tx_sync
);

  lnk_char_t nxt;
  logic      in_frame;
  logic      resume_q;
  logic      frame_open;
  logic      sync_n;

  assign frame_open = accept & ~src_eof & ~in_frame;
  assign sync_n     = resume_q | frame_open;

  always_comb begin
    nxt = mk_ctl(CODE_IDL);
    if (seq_start)   nxt = mk_ctl(CODE_EOF);
    else if (accept) nxt = src_eof ? mk_ctl(CODE_EOF) : mk_data(src_data);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_char  <= mk_ctl(CODE_IDL);
      tx_sync  <= 1'b0;
      in_frame <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      tx_char  <= nxt;
      tx_sync  <= sync_n;
      resume_q <= seq_done;
      if (seq_start)   in_frame <= 1'b0;
      else if (accept) in_frame <= ~src_eof;
    end
  end

  // R3
  data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !src_eof) |=> (!tx_char.ctl && tx_char.val == $past(src_data)));

  // R11
  ctl_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_char.ctl |-> is_ctl_code(tx_char.val));

endmodule

// File: rtl/lnk_tx_framer.sv
module lnk_tx_framer
  import lnk_tx_pkg::*;
#(
  parameter int DRAIN_LEN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_valid,
  input  logic [7:0] src_data,
  input  logic       src_eof,
  output logic       src_ready,
  input  logic       lb_req,
  output logic       tx_ctl,
  output logic [7:0] tx_val,
  output logic       tx_sync,
  output logic       lpbk_out
);

  phase_e    phase;
  logic      pend;
  logic      seq_start;
  logic      lb_flip;
  logic      seq_done;
  logic      accept;
  lnk_char_t tx_char;

  lnk_tx_seq #(.DRAIN_LEN(DRAIN_LEN)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .lb_req    (lb_req),
    .phase     (phase),
    .pend      (pend),
    .seq_start (seq_start),
    .lb_flip   (lb_flip),
    .seq_done  (seq_done),
    .lb_state  (lpbk_out)
  );

  assign src_ready = (phase == PH_RUN) && !pend;
  assign accept    = src_valid && src_ready;

  lnk_tx_charsel u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .src_data  (src_data),
    .src_eof   (src_eof),
    .seq_start (seq_start),
    .seq_done  (seq_done),
    .tx_char   (tx_char),
    .tx_sync   (tx_sync)
  );

  assign tx_ctl = tx_char.ctl;
  assign tx_val = tx_char.val;

  // R6
  start_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> (tx_ctl && tx_val == CODE_EOF && !src_ready));

  // R7
  lb_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lb_flip |=> (lpbk_out != $past(lpbk_out)));

  // R8
  resume_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> ##1 tx_sync);

endmodule

// File: tb/sim_lnk_tx_framer.sv
`timescale 1ns/1ps
module sim_lnk_tx_framer;

  typedef struct packed {
    logic       ctl;
    logic [7:0] val;
    logic       sync;
    logic       lb;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_valid = 1'b0;
  logic [7:0] src_data = 8'h00;
  logic       src_eof = 1'b0;
  logic       lb_req = 1'b0;
  logic       src_ready, tx_ctl, tx_sync, lpbk_out;
  logic [7:0] tx_val;

  int   n_chk = 0;
  int   n_fail = 0;
  exp_t q_exp[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  lnk_tx_framer u0 (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
    .src_eof(src_eof), .src_ready(src_ready), .lb_req(lb_req),
    .tx_ctl(tx_ctl), .tx_val(tx_val), .tx_sync(tx_sync), .lpbk_out(lpbk_out)
  );

  task automatic step(input logic v, input logic [7:0] d, input logic e, input logic l,
                      input logic rdy, input logic ec, input logic [7:0] ev,
                      input logic es, input logic el, input string tag);
    exp_t x;
    @(negedge clk);
    src_valid = v; src_data = d; src_eof = e; lb_req = l;
    n_chk++;
    if (src_ready !== rdy) begin
      n_fail++;
      $display("FAIL %s ready: got %b expected %b", tag, src_ready, rdy);
    end
    x.ctl = ec; x.val = ev; x.sync = es; x.lb = el;
    q_exp.push_back(x);
    q_tag.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_exp.size() > 0) begin
        exp_t x;
        string t;
        x = q_exp.pop_front();
        t = q_tag.pop_front();
        n_chk++;
        if (tx_ctl !== x.ctl || tx_val !== x.val || tx_sync !== x.sync || lpbk_out !== x.lb) begin
          n_fail++;
          $display("FAIL %s char: got ctl=%b val=%h sync=%b lb=%b expected ctl=%b val=%h sync=%b lb=%b",
                   t, tx_ctl, tx_val, tx_sync, lpbk_out, x.ctl, x.val, x.sync, x.lb);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R8: got no completion, expected end of run");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    n_chk++;
    if (tx_ctl !== 1'b1 || tx_val !== 8'hEE || tx_sync !== 1'b0 || lpbk_out !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset char: got %b/%h/%b/%b expected 1/ee/0/0", tx_ctl, tx_val, tx_sync, lpbk_out);
    end
    n_chk++;
    if (src_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 reset ready: got %b expected 1", src_ready);
    end
    rst_n = 1'b1;

    // R2 idle fill
    step(0, 8'h00, 0, 0, 1, 1, 8'hEE, 0, 0, "R2");
    step(0, 8'h00, 0, 0, 1, 1, 8'hEE, 0, 0, "R2");

    // R3 R4 R5 basic frame
    step(1, 8'hA1, 0, 0, 1, 0, 8'hA1, 1, 0, "R5");
    step(1, 8'h5C, 0, 0, 1, 0, 8'h5C, 0, 0, "R5");
    step(1, 8'hFF, 0, 0, 1, 0, 8'hFF, 0, 0, "R3");
    step(1, 8'h00, 0, 0, 1, 0, 8'h00, 0, 0, "R3");
    step(1, 8'h00, 1, 0, 1, 1, 8'hD0, 0, 0, "R4");
    step(0, 8'h00, 0, 0, 1, 1, 8'hEE, 0, 0, "R2");

    // R5 idle inside a frame keeps it open
    step(1, 8'h11, 0, 0, 1, 0, 8'h11, 1, 0, "R5");
    step(0, 8'h00, 0, 0, 1, 1, 8'hEE, 0, 0, "R5");
    step(1, 8'h22, 0, 0, 1, 0, 8'h22, 0, 0, "R5");
    step(1, 8'h00, 1, 0, 1, 1, 8'hD0, 0, 0, "R4");
    step(1, 8'h00, 1, 0, 1, 1, 8'hD0, 0, 0, "R4");
    step(1, 8'h77, 0, 0, 1, 0, 8'h77, 1, 0, "R5");
    step(1, 8'h00, 1, 0, 1, 1, 8'hD0, 0, 0, "R4");

    // Enter loopback: request together with an accepted byte
    step(1, 8'h33, 0, 1, 1, 0, 8'h33, 1, 0, "R5");
    step(1, 8'h44, 0, 0, 0, 1, 8'hD0, 0, 0, "R6");
    for (int i = 0; i < 16; i++) step(1, 8'h44, 0, 0, 0, 1, 8'hEE, 0, 0, "R6");
    for (int i = 0; i < 16; i++) step(1, 8'h44, 0, 0, 0, 1, 8'hEE, 0, 1, "R7");
    step(1, 8'h44, 0, 0, 1, 0, 8'h44, 1, 1, "R8");
    step(1, 8'h45, 0, 0, 1, 0, 8'h45, 0, 1, "R9");
    step(1, 8'h00, 1, 0, 1, 1, 8'hD0, 0, 1, "R4");

    // Leave loopback, with a second request held mid-sequence
    step(0, 8'h00, 0, 1, 1, 1, 8'hEE, 0, 1, "R2");
    step(0, 8'h00, 0, 0, 0, 1, 8'hD0, 0, 1, "R6");
    for (int i = 0; i < 16; i++)
      step(0, 8'h00, 0, (i == 5), 0, 1, 8'hEE, 0, 1, "R9");
    for (int i = 0; i < 16; i++) step(0, 8'h00, 0, 0, 0, 1, 8'hEE, 0, 0, "R7");
    step(1, 8'h55, 0, 0, 0, 1, 8'hD0, 1, 0, "R10");
    for (int i = 0; i < 16; i++) step(1, 8'h55, 0, 0, 0, 1, 8'hEE, 0, 0, "R10");
    for (int i = 0; i < 16; i++) step(0, 8'h00, 0, 0, 0, 1, 8'hEE, 0, 1, "R7");
    step(0, 8'h00, 0, 0, 1, 1, 8'hEE, 1, 1, "R8");
    step(1, 8'h66, 0, 0, 1, 0, 8'h66, 1, 1, "R5");
    step(1, 8'h00, 1, 0, 1, 1, 8'hD0, 0, 1, "R4");
    step(0, 8'h00, 0, 0, 1, 1, 8'hEE, 0, 1, "R2");

    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule